// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A clocked single-port memory with byte lanes that sits behind a burst address generator. It registers every command input on the rising clock edge: address, write data, three chip selects, a global-write strobe, a byte-write enable and one strobe per byte lane. It then commits writes to the array and returns reads on a read data bus. The array depth is set by a parameter, so a 32K-word part uses `ADDR_W = 15`. The default is kept small.

A level input, `pipe_en`, picks the read timing while the core runs. With `pipe_en` high, read data passes through an output register and appears two edges after the command. With it low, read data flows straight from the array and appears one edge after the command. The bus driver enable `rd_drive` follows single-cycle-deselect timing. Output enable and sleep act on `rd_drive` without waiting for a clock edge. Sleep also blocks new commands and leaves the stored contents untouched.

A new command, with any address, may be issued on every cycle.

Top module: `sbs_sram_core`

## Requirements
- R1: A command is accepted only if, at the sampling edge, `sel1_n` is 0, `sel2` is 1 and `sel3_n` is 0. Any other combination is a deselect: no write takes place and the cycle's output slot is not driven.
- R2: When `gwr_n` is 0 at the sampling edge, all byte lanes of the word are written, whatever `bwr_n` and `lane_n` are.
- R3: With `gwr_n` at 1 and `bwr_n` at 0, only lane i is written for each `lane_n[i]` that is 0. Lane i is bits 8i+7..8i. If `bwr_n` is 0 but no `lane_n` bit is 0, the cycle is a read.
- R4: With `pipe_en` at 0, the data for a read sampled at edge k is on `rd_data`, with `rd_drive` at 1, right after edge k.
- R5: With `pipe_en` at 1, the data for a read sampled at edge k appears right after edge k+1. If the command before it was not a read, `rd_drive` is 0 between edges k and k+1.
- R6: Reads and writes may be issued back to back with a new address on every cycle. A read issued in the cycle after a write to the same address returns the new data.
- R7: Deselect is single-cycle. With `pipe_en` at 0, `rd_drive` falls right after the edge that samples the deselect. With `pipe_en` at 1, it falls right after the next edge, which is the edge at which a read's data would have appeared.
- R8: `oe_n` at 1 forces `rd_drive` to 0 at once, without a clock edge. `rd_data` reads 0 whenever `rd_drive` is 0.
- R9: `sleep` at 1 forces `rd_drive` to 0 at once. Commands sampled while `sleep` is 1 are ignored, and the stored data is retained through sleep.
- R10: A write never drives the bus. The output slot of a write cycle has `rd_drive` at 0.
- R11: After reset, `rd_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| addr | input | ADDR_W | Word address, registered |
| wdata | input | DATA_W | Write data, registered |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_n | input | DATA_W/8 | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low, acts without a clock edge |
| sleep | input | 1 | Low-power request, active high, acts without a clock edge |
| pipe_en | input | 1 | 1 = registered read output, 0 = flow-through read |
| rd_data | output | DATA_W | Read data, 0 while not driven |
| rd_drive | output | 1 | Bus driver enable |

## Verification
Two functions can fall in the same cycle. In pipelined mode, a read issued just before a deselect or a write has its data on the bus in the very cycle in which the deselect or write is being registered. The bench provokes this with a read followed at once by a deselect, and with a read followed at once by a write. It then judges that the read's word is driven for exactly one cycle and that the following slot is undriven. The second overlap is a write followed by a read of the same address on the next cycle. That read must see the freshly committed word.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Command decode: an accepted cycle with any lane enabled is a write.
  function automatic op_e decode_op(input logic accept, input logic any_lane);
    if (!accept) return OP_IDLE;
    return any_lane ? OP_WRITE : OP_READ;
  endfunction

endpackage

// File: rtl/sbs_cmd_reg.sv
module sbs_cmd_reg
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  parameter int NB     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              gwr_n,
  input  logic              bwr_n,
  input  logic [NB-1:0]     lane_n,
  input  logic              sleep,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [NB-1:0]     mask_q
);

  // Lane select: the global write overrides the byte path.
  function automatic logic [NB-1:0] lane_mask(input logic g_n, input logic b_n,
                                               input logic [NB-1:0] l_n);
    if (!g_n) return '1;
    if (!b_n) return ~l_n;
    return '0;
  endfunction

  logic          sel_ok;
  logic          accept;
  logic [NB-1:0] mask_d;
  op_e           op_d;

  assign sel_ok = !sel1_n && sel2 && !sel3_n;
  assign accept = sel_ok && !sleep;
  assign mask_d = lane_mask(gwr_n, bwr_n, lane_n);
  assign op_d   = decode_op(accept, |mask_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      mask_q <= '0;
    end else begin
      op_q   <= op_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr;
    wdata_q <= wdata;
  end

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sel_ok) |-> op_q == OP_IDLE);  // R1
  AST_SLEEP_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep) |-> op_q == OP_IDLE);  // R9
  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept) && !$past(gwr_n)) |-> (op_q == OP_WRITE && mask_q == '1));  // R2

endmodule

// File: rtl/sbs_array.sv
module sbs_array
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  parameter int NB     = 4
) (
  input  logic              clk,
  input  op_e               op_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [NB-1:0]     mask_q,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / NB;

  logic wr_en;
  assign wr_en = (op_q == OP_WRITE);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && mask_q[g]) mem[addr_q] <= wdata_q[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[addr_q];
  end

  AST_WRITE_HAS_LANE: assert property (@(posedge clk)
    wr_en |-> mask_q != '0);  // R3

endmodule

// File: rtl/sbs_rd_path.sv
module sbs_rd_path
  import sbs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op_q,
  input  logic [DATA_W-1:0] rdata,
  input  logic              pipe_en,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);

  logic [DATA_W-1:0] out_q;
  logic              vld_q;
  logic              rd_now;
  logic              slot_vld;
  logic [DATA_W-1:0] slot_data;

  assign rd_now = (op_q == OP_READ);

  // Output register stage. Deselects and writes clear the valid bit one stage
  // ahead of where a read's data would sit.
  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= rd_now;
  end

  always_ff @(posedge clk) begin
    if (rd_now) out_q <= rdata;
  end

  assign slot_vld  = pipe_en ? vld_q : rd_now;
  assign slot_data = pipe_en ? out_q : rdata;
  assign rd_drive  = slot_vld && !oe_n && !sleep;
  assign rd_data   = rd_drive ? slot_data : '0;

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rd_drive);  // R8
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rd_drive);  // R9
  AST_PIPE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_en && $past(pipe_en) && $past(rd_now) && !oe_n && !sleep)
      |-> (rd_drive && rd_data == $past(rdata)));  // R5
  AST_FLOW_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_en && op_q == OP_IDLE) |-> !rd_drive);  // R7
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_en && $past(pipe_en) && $past(op_q == OP_WRITE)) |-> !rd_drive);  // R10

endmodule

// File: rtl/sbs_sram_core.sv
module sbs_sram_core
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                sel1_n,
  input  logic                sel2,
  input  logic                sel3_n,
  input  logic                gwr_n,
  input  logic                bwr_n,
  input  logic [DATA_W/8-1:0] lane_n,
  input  logic                oe_n,
  input  logic                sleep,
  input  logic                pipe_en,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_drive
);

  localparam int NB = DATA_W / 8;

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [NB-1:0]     mask_q;
  logic [DATA_W-1:0] arr_rdata;

  sbs_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NB(NB)) u_cmd (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n), .sleep(sleep),
    .op_q(op_q), .addr_q(addr_q), .wdata_q(wdata_q), .mask_q(mask_q)
  );

  sbs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NB(NB)) u_arr (
    .clk(clk), .op_q(op_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .mask_q(mask_q), .rdata(arr_rdata)
  );

  sbs_rd_path #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .op_q(op_q), .rdata(arr_rdata),
    .pipe_en(pipe_en), .oe_n(oe_n), .sleep(sleep),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !rd_drive);  // R11

endmodule

// File: tb/test_sbs_sram_core.sv
module test_sbs_sram_core;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic          gwr_n = 1'b1, bwr_n = 1'b1;
  logic [3:0]    lane_n = 4'hF;
  logic          oe_n = 1'b0, sleep = 1'b0, pipe_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_drive;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbs_sram_core #(.ADDR_W(AW), .DATA_W(DW)) i_sbs_sram_core (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n),
    .oe_n(oe_n), .sleep(sleep), .pipe_en(pipe_en),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sel_on();
    sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
  endtask

  task automatic drv_idle();
    sel1_n = 1'b1; sel2 = 1'b0; sel3_n = 1'b1;
    gwr_n = 1'b1; bwr_n = 1'b1; lane_n = 4'hF;
  endtask

  task automatic drv_read(input logic [AW-1:0] a);
    sel_on(); gwr_n = 1'b1; bwr_n = 1'b1; lane_n = 4'hF; addr = a;
  endtask

  task automatic drv_gw(input logic [AW-1:0] a, input logic [DW-1:0] d);
    sel_on(); gwr_n = 1'b0; bwr_n = 1'b1; lane_n = 4'hF; addr = a; wdata = d;
  endtask

  task automatic drv_bw(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] lanes);
    sel_on(); gwr_n = 1'b1; bwr_n = 1'b0; lane_n = ~lanes; addr = a; wdata = d;
  endtask

  // Flow-through read returning data right after its sampling edge.
  task automatic flow_read_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    pipe_en = 1'b0;
    drv_read(a); tick();
    chk(req, {31'd0, rd_drive}, 32'd1);
    chk(req, rd_data, exp);
    drv_idle();
  endtask

  task automatic t_reset();
    chk("R11 drive after reset", {31'd0, rd_drive}, 32'd0);
    chk("R11 data after reset", rd_data, 32'd0);
  endtask

  task automatic t_global();
    pipe_en = 1'b0;
    drv_gw(11'h010, 32'hDEADBEEF); tick();
    drv_idle(); tick();
    flow_read_chk("R2 global write / R4 flow read", 11'h010, 32'hDEADBEEF);
    // global write while byte enable low and only lane 0 strobed
    sel_on(); gwr_n = 1'b0; bwr_n = 1'b0; lane_n = 4'b1110; addr = 11'h010; wdata = 32'h01020304;
    tick(); drv_idle(); tick();
    flow_read_chk("R2 override of byte strobes", 11'h010, 32'h01020304);
  endtask

  task automatic t_bytes();
    drv_gw(11'h020, 32'hFFFFFFFF); tick();
    drv_bw(11'h020, 32'h12345678, 4'b0101); tick();
    drv_idle(); tick();
    flow_read_chk("R3 lanes 0 and 2 only", 11'h020, 32'hFF34FF78);
    // byte enable low with no lane strobe is a read
    pipe_en = 1'b0;
    drv_bw(11'h020, 32'h00000000, 4'b0000); tick();
    chk("R3 empty strobe acts as read drive", {31'd0, rd_drive}, 32'd1);
    chk("R3 empty strobe acts as read data", rd_data, 32'hFF34FF78);
    drv_idle(); tick();
  endtask

  task automatic t_pipe();
    drv_gw(11'h031, 32'hAAAA0001); tick();
    drv_gw(11'h032, 32'hAAAA0002); tick();
    drv_gw(11'h033, 32'hAAAA0003); tick();
    drv_idle(); tick();
    pipe_en = 1'b1; tick();
    drv_read(11'h031); tick();
    chk("R5 no drive one edge after read", {31'd0, rd_drive}, 32'd0);
    drv_read(11'h032); tick();
    chk("R5 drive two edges after read", {31'd0, rd_drive}, 32'd1);
    chk("R5 pipelined data", rd_data, 32'hAAAA0001);
    drv_read(11'h033); tick();
    chk("R6 back-to-back read 2", rd_data, 32'hAAAA0002);
    drv_idle(); tick();
    chk("R6 back-to-back read 3", rd_data, 32'hAAAA0003);
    tick();
    chk("R7 pipelined deselect drops drive", {31'd0, rd_drive}, 32'd0);
  endtask

  task automatic t_raw();
    pipe_en = 1'b0;
    drv_gw(11'h040, 32'h5A5A5A5A); tick();
    drv_read(11'h040); tick();
    chk("R6 flow read after write", rd_data, 32'h5A5A5A5A);
    drv_idle(); tick();
    pipe_en = 1'b1; tick();
    drv_gw(11'h040, 32'hC3C3C3C3); tick();
    drv_read(11'h040); tick();
    chk("R10 pipelined write slot undriven", {31'd0, rd_drive}, 32'd0);
    drv_idle(); tick();
    chk("R6 pipelined read after write", rd_data, 32'hC3C3C3C3);
    tick();
    pipe_en = 1'b0;
  endtask

  task automatic t_desel();
    pipe_en = 1'b0;
    drv_read(11'h010); tick();
    chk("R7 flow read drives", {31'd0, rd_drive}, 32'd1);
    drv_idle(); tick();
    chk("R7 flow deselect off at capture edge", {31'd0, rd_drive}, 32'd0);
    pipe_en = 1'b1; tick();
    drv_read(11'h010); tick();
    drv_idle(); tick();
    chk("R7 pipelined read before deselect drives", rd_data, 32'h01020304);
    tick();
    chk("R7 pipelined deselect off next edge", {31'd0, rd_drive}, 32'd0);
    // read followed at once by a write in pipelined mode
    drv_read(11'h010); tick();
    drv_gw(11'h050, 32'h0BADF00D); tick();
    chk("R10 read data before write", rd_data, 32'h01020304);
    drv_idle(); tick();
    chk("R10 write slot undriven", {31'd0, rd_drive}, 32'd0);
    pipe_en = 1'b0;
    drv_gw(11'h050, 32'h0BADF00D); tick();
    chk("R10 flow write slot undriven", {31'd0, rd_drive}, 32'd0);
    drv_idle(); tick();
  endtask

  task automatic t_chipsel();
    drv_gw(11'h060, 32'h11112222); tick();
    drv_idle(); tick();
    for (int i = 0; i < 3; i++) begin
      drv_gw(11'h060, 32'h99999999 + i);
      if (i == 0) sel1_n = 1'b1;
      if (i == 1) sel2 = 1'b0;
      if (i == 2) sel3_n = 1'b1;
      tick();
      chk("R1 deselect slot undriven", {31'd0, rd_drive}, 32'd0);
      drv_idle(); tick();
      flow_read_chk("R1 write ignored when one select off", 11'h060, 32'h11112222);
    end
  endtask

  task automatic t_oe();
    pipe_en = 1'b0;
    drv_read(11'h060); tick();
    oe_n = 1'b1; #1;
    chk("R8 oe off drops drive", {31'd0, rd_drive}, 32'd0);
    chk("R8 data zero while undriven", rd_data, 32'd0);
    oe_n = 1'b0; #1;
    chk("R8 oe on restores drive", rd_data, 32'h11112222);
    drv_idle(); tick();
  endtask

  task automatic t_sleep();
    pipe_en = 1'b0;
    drv_read(11'h060); tick();
    sleep = 1'b1; #1;
    chk("R9 sleep drops drive", {31'd0, rd_drive}, 32'd0);
    drv_gw(11'h060, 32'hEEEEEEEE); tick();
    drv_read(11'h060); tick();
    chk("R9 no drive while asleep", {31'd0, rd_drive}, 32'd0);
    drv_idle(); sleep = 1'b0; tick();
    flow_read_chk("R9 contents retained, sleep write ignored", 11'h060, 32'h11112222);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_global();
    t_bytes();
    t_pipe();
    t_raw();
    t_desel();
    t_chipsel();
    t_oe();
    t_sleep();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule